// File: doc/BRIEF.md
# Ordered Store Queue With Load Forwarding

This block sits between a processor's memory pipeline and its data cache. Stores are written into a small circular queue in program order, then handed to the cache one at a time, oldest first. Other agents therefore observe this processor's writes in the order they were issued. Loads do not queue behind these stores. Each load is compared against the queued stores in the same cycle. If no queued store touches its bytes, the load goes straight to the cache. If the youngest store that touches its bytes covers all of them, the load takes its data from the queue.

Three interfaces use valid/ready handshakes:

- **Store port.** A store is accepted when `st_valid` and `st_ready` are both high. `st_ready` falls while every slot is occupied.
- **Drain port.** The queue offers its oldest not-yet-issued store on `dr_*`. That store is issued when `dr_ready` is high. While `dr_ready` is low, the offered address, data and enables hold steady.
- **Load port.** `ld_ready` drops only when the youngest overlapping store covers part of the load's bytes. The load must then be held and retried until that store has left the queue.

Issuing a store does not free its slot. A slot is released only by a later `dr_ack` pulse from the cache, so an issued store keeps forwarding data until it is acknowledged. `drained` is a plain status pin. A fence unit can wait on it to know that every earlier store has been performed.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset, `drained` and `st_ready` are high, while `dr_valid` and `ld_hit` are low.
- R2: A store is captured on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` is low exactly while DEPTH entries are held, and a store offered during that time is not captured.
- R3: `dr_valid` is high while some held entry has not been issued. `dr_addr`/`dr_data`/`dr_be` then show the oldest such entry, so entries are issued in the order they were captured. While `dr_ready` is low, those outputs stay stable.
- R4: A slot is freed only by a `dr_ack` pulse, and each pulse frees the oldest issued entry. A pulse while no issued entry is outstanding changes nothing.
- R5: `drained` is high exactly when no entry is held, which includes issued but unacknowledged entries.
- R6: A load is compared in the same cycle, with no register in the path. Byte-enable bit i covers data bits 8i+7..8i, and two accesses overlap when their word addresses are equal and their enables share a set bit. A valid load that overlaps no held entry gives `ld_hit`=0 and `ld_ready`=1.
- R7: A valid load whose youngest overlapping entry covers all of its enabled bytes gives `ld_hit`=1 and `ld_ready`=1. `ld_data` carries that entry's bytes in enabled lanes and zero in the other lanes.
- R8: When several held entries overlap a load, only the youngest one decides the result, even if an older entry covers the load fully.
- R9: If the youngest overlapping entry lacks some of the load's enabled bytes, the outputs are `ld_ready`=0 and `ld_hit`=0, with no merge of bytes. They stay that way until that entry is freed or a younger store changes the match.
- R10: Loads are compared and answered normally while the queue is full and stores are stalled.
- R11: Issued entries that are waiting for acknowledgement still take part in forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be captured (queue not full) |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_ready | output | 1 | Low when load must wait for a partially overlapping store |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Load byte enables |
| ld_hit | output | 1 | Load data supplied by the queue |
| ld_data | output | DW | Forwarded data, enabled lanes only |
| dr_valid | output | 1 | Oldest unissued store offered to the cache |
| dr_ready | input | 1 | Cache takes the offered store |
| dr_addr | output | AW | Offered store word address |
| dr_data | output | DW | Offered store data |
| dr_be | output | DW/8 | Offered store byte enables |
| dr_ack | input | 1 | Cache has performed the oldest issued store |
| drained | output | 1 | No store held or pending |

## Verification
The hardest case to reach from the ports is a load that overlaps a full queue holding several entries at one address, some issued and unacknowledged, where the youngest covers only part of the load. The stimulus draws addresses from a four-word pool and byte enables at random, so matches are frequent. It alternates phases with rare and frequent `dr_ack` pulses, so the queue both fills up and holds issued entries for long stretches. Directed sequences add a full queue with loads, a stray acknowledgement, and a youngest-partial entry shadowing an older full one.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_FWD  = 2'd1,
    LK_WAIT = 2'd2
  } lookup_e;

endpackage

// File: rtl/sfb_queue.sv
module sfb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_fire,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  input  logic [BW-1:0] enq_be,
  input  logic          iss_ready,
  input  logic          ack_in,
  output logic          full,
  output logic          iss_valid,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data,
  output logic [BW-1:0] iss_be,
  output logic          ack_ok,
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [DW-1:0] slot_data [DEPTH],
  output logic [BW-1:0] slot_be   [DEPTH],
  output logic [PW-1:0] head,
  output logic [CW-1:0] cnt
);

  logic [PW-1:0] tail;
  logic [PW-1:0] iss_ptr;
  logic [CW-1:0] nout;
  logic          iss_fire;

  assign full      = (cnt == CW'(DEPTH));
  assign iss_valid = (cnt > nout);
  assign iss_fire  = iss_valid && iss_ready;
  assign ack_ok    = ack_in && (nout != '0);
  assign iss_addr  = slot_addr[iss_ptr];
  assign iss_data  = slot_data[iss_ptr];
  assign iss_be    = slot_be[iss_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      iss_ptr <= '0;
      cnt     <= '0;
      nout    <= '0;
    end else begin
      if (enq_fire) tail <= tail + PW'(1);
      if (ack_ok) head <= head + PW'(1);
      if (iss_fire) iss_ptr <= iss_ptr + PW'(1);
      cnt  <= cnt + CW'(enq_fire) - CW'(ack_ok);
      nout <= nout + CW'(iss_fire) - CW'(ack_ok);
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[s] <= '0;
        slot_data[s] <= '0;
        slot_be[s]   <= '0;
      end else if (enq_fire && (tail == PW'(s))) begin
        slot_addr[s] <= enq_addr;
        slot_data[s] <= enq_data;
        slot_be[s]   <= enq_be;
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_enq_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && !ack_ok) |=> (cnt == $past(cnt) + CW'(1)));

  assert_out_le_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nout <= cnt);

  assert_free_only_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_ok |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/sfb_match.sv
module sfb_match
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [BW-1:0] slot_be   [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] q_addr,
  input  logic [BW-1:0] q_be,
  output lookup_e       result,
  output logic [DW-1:0] fwd_data
);

  logic          found;
  logic [PW-1:0] sel;
  logic [PW-1:0] idx;

  // Walk from oldest to youngest; the last overlap seen is the youngest.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if ((CW'(k) < cnt) && (slot_addr[idx] == q_addr) &&
          ((slot_be[idx] & q_be) != '0)) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  always_comb begin
    if (!found)
      result = LK_MISS;
    else if ((q_be & ~slot_be[sel]) == '0)
      result = LK_FWD;
    else
      result = LK_WAIT;
  end

  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign fwd_data[8*b +: 8] = ((result == LK_FWD) && q_be[b]) ?
                                slot_data[sel][8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          dr_valid,
  input  logic          dr_ready,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  output logic [BW-1:0] dr_be,
  input  logic          dr_ack,
  output logic          drained
);

  logic          full;
  logic          enq_fire;
  logic          ack_ok;
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [BW-1:0] slot_be   [DEPTH];
  logic [PW-1:0] head;
  logic [CW-1:0] cnt;
  lookup_e       result;
  logic [DW-1:0] fwd_data;

  assign st_ready = !full;
  assign enq_fire = st_valid && st_ready;

  sfb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_fire  (enq_fire),
    .enq_addr  (st_addr),
    .enq_data  (st_data),
    .enq_be    (st_be),
    .iss_ready (dr_ready),
    .ack_in    (dr_ack),
    .full      (full),
    .iss_valid (dr_valid),
    .iss_addr  (dr_addr),
    .iss_data  (dr_data),
    .iss_be    (dr_be),
    .ack_ok    (ack_ok),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_be   (slot_be),
    .head      (head),
    .cnt       (cnt)
  );

  sfb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_be   (slot_be),
    .head      (head),
    .cnt       (cnt),
    .q_addr    (ld_addr),
    .q_be      (ld_be),
    .result    (result),
    .fwd_data  (fwd_data)
  );

  assign ld_ready = !(ld_valid && (result == LK_WAIT));
  assign ld_hit   = ld_valid && (result == LK_FWD);
  assign ld_data  = ld_hit ? fwd_data : '0;
  assign drained  = (cnt == '0);

  assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=>
      (dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_be)));

  assert_drained_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !dr_valid);

  assert_hit_is_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_ready);

  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready && !ack_ok && !enq_fire) |=>
      (!ld_ready || !ld_valid || !$stable(ld_addr) || !$stable(ld_be)));

endmodule

// File: tb/sim_store_fwd_buffer.sv
`timescale 1ns/100ps
module sim_store_fwd_buffer;

  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [BW-1:0] st_be;
  logic          ld_valid, ld_ready, ld_hit;
  logic [AW-1:0] ld_addr;
  logic [BW-1:0] ld_be;
  logic [DW-1:0] ld_data;
  logic          dr_valid, dr_ready, dr_ack, drained;
  logic [AW-1:0] dr_addr;
  logic [DW-1:0] dr_data;
  logic [BW-1:0] dr_be;

  always #2.5 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

  int checks = 0;
  int errors = 0;

  // reference model: index 0 is the oldest held entry
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  logic [BW-1:0] m_be   [DEPTH];
  int m_cnt  = 0;
  int m_nout = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // one cycle: drive at negedge, check, then advance model at posedge
  task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [BW-1:0] sb, input bit lv, input logic [AW-1:0] la,
                      input logic [BW-1:0] lb, input bit drr, input bit ack);
    int sel;
    int nmatch;
    bit e_hit, e_wait, st_f, is_f, ack_f;
    logic [DW-1:0] e_data;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    ld_valid = lv; ld_addr = la; ld_be = lb;
    dr_ready = drr; dr_ack = ack;
    #1;
    chk(st_ready == (m_cnt < DEPTH), (m_cnt == DEPTH) ? "R2 st_ready full" : "R2 st_ready",
        64'(st_ready), 64'(m_cnt < DEPTH));
    chk(drained == (m_cnt == 0), "R5 drained", 64'(drained), 64'(m_cnt == 0));
    chk(dr_valid == (m_cnt > m_nout), "R3 dr_valid", 64'(dr_valid), 64'(m_cnt > m_nout));
    if (m_cnt > m_nout)
      chk({dr_addr, dr_data, dr_be} == {m_addr[m_nout], m_data[m_nout], m_be[m_nout]},
          "R3 drain order", 64'({dr_addr, dr_data, dr_be}),
          64'({m_addr[m_nout], m_data[m_nout], m_be[m_nout]}));
    sel = -1; nmatch = 0;
    for (int k = 0; k < m_cnt; k++)
      if (m_addr[k] == la && (m_be[k] & lb) != '0) begin sel = k; nmatch++; end
    e_hit  = lv && sel >= 0 && ((lb & ~m_be[(sel < 0) ? 0 : sel]) == '0);
    e_wait = lv && sel >= 0 && !e_hit;
    e_data = e_hit ? (m_data[sel] & lane_mask(lb)) : '0;
    if (lv) begin
      if (sel < 0)
        chk(ld_hit == 1'b0 && ld_ready == 1'b1, "R6 miss", 64'({ld_hit, ld_ready}), 64'b01);
      else if (e_wait)
        chk(ld_hit == 1'b0 && ld_ready == 1'b0, "R9 partial wait",
            64'({ld_hit, ld_ready}), 64'b00);
      else
        chk(ld_hit && ld_ready && ld_data == e_data,
            (nmatch > 1) ? "R8 youngest fwd" : (sel < m_nout) ? "R11 issued fwd" :
            (m_cnt == DEPTH) ? "R10 fwd full" : "R7 fwd",
            64'({ld_hit, ld_ready, ld_data}), 64'({2'b11, e_data}));
    end
    st_f  = sv && (m_cnt < DEPTH);
    is_f  = (m_cnt > m_nout) && drr;
    ack_f = ack && (m_nout > 0);
    @(posedge clk);
    if (ack_f) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        m_addr[k] = m_addr[k+1]; m_data[k] = m_data[k+1]; m_be[k] = m_be[k+1];
      end
      m_cnt--;
    end
    m_nout = m_nout + int'(is_f) - int'(ack_f);
    if (st_f) begin
      m_addr[m_cnt] = sa; m_data[m_cnt] = sd; m_be[m_cnt] = sb; m_cnt++;
    end
  endtask

  task automatic idle();
    step(0, '0, '0, '0, 0, '0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    st_valid = 0; st_addr = '0; st_data = '0; st_be = '0;
    ld_valid = 0; ld_addr = '0; ld_be = '0; dr_ready = 0; dr_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(drained && st_ready && !dr_valid && !ld_hit, "R1 reset state",
        64'({drained, st_ready, dr_valid, ld_hit}), 64'b1100);

    // fill to full, stall a store, loads while full (R2, R10, R8)
    step(1, 8'h10, 32'h11111111, 4'hF, 0, '0, '0, 0, 0);
    step(1, 8'h10, 32'h22222222, 4'h3, 1, 8'h10, 4'hC, 0, 0);
    step(1, 8'h20, 32'h33333333, 4'hF, 1, 8'h10, 4'h1, 0, 0);
    step(1, 8'h30, 32'h44444444, 4'hF, 1, 8'h10, 4'hF, 0, 0);
    step(1, 8'h40, 32'h55555555, 4'hF, 1, 8'h20, 4'h6, 0, 0);
    step(0, '0, '0, '0, 1, 8'h30, 4'h8, 0, 0);
    // stray ack with nothing issued is ignored (R4)
    step(0, '0, '0, '0, 1, 8'h50, 4'hF, 0, 1);
    step(0, '0, '0, '0, 0, '0, '0, 0, 0);
    // issue two, no ack: still held and forwarding (R4, R11)
    step(0, '0, '0, '0, 0, '0, '0, 1, 0);
    step(0, '0, '0, '0, 1, 8'h10, 4'h3, 1, 0);
    step(0, '0, '0, '0, 1, 8'h10, 4'h3, 0, 0);
    step(0, '0, '0, '0, 0, '0, '0, 0, 1);
    step(0, '0, '0, '0, 1, 8'h10, 4'hF, 0, 1);
    step(0, '0, '0, '0, 1, 8'h10, 4'hF, 1, 0);
    step(0, '0, '0, '0, 1, 8'h10, 4'hF, 1, 1);
    step(0, '0, '0, '0, 0, '0, '0, 0, 1);
    step(0, '0, '0, '0, 0, '0, '0, 0, 1);
    idle();

    // random phases: rare and frequent acknowledgements
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        int ackp;
        ackp = (ph % 2 == 0) ? 8 : 70;
        step($urandom_range(99) < 60, AW'($urandom_range(3)), $urandom,
             ($urandom_range(3) == 0) ? 4'hF : BW'($urandom_range(15, 1)),
             $urandom_range(99) < 80, AW'($urandom_range(3)),
             ($urandom_range(3) == 0) ? 4'hF : BW'($urandom_range(15, 1)),
             $urandom_range(99) < 60, $urandom_range(99) < ackp);
      end
    end
    // empty everything and confirm drained (R5)
    for (int c = 0; c < 4 * DEPTH; c++) step(0, '0, '0, '0, 0, '0, '0, 1, 1);
    chk(drained == 1'b1, "R5 final drained", 64'(drained), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule